// File: doc/BRIEF.md
# Interlaced Master Sync Generator

This block produces the horizontal and vertical timing of a digital video encoder that runs as the timing master. It counts bus clocks of the 27 MHz multiplexed Cb/Y/Cr pixel stream across each line, and lines across each interlaced frame. From these two counters it drives an active-low horizontal sync, an active-low vertical sync, a field identifier and a vertical-interval blanking flag. It also exposes the current line number and pixel-slot index so that downstream processing can align to them. A single select input chooses between the 525-line and the 625-line systems. A second input turns off blanking of the vertical interval.

The field is signalled by the phase of the vertical sync falling edge relative to the horizontal sync falling edge. In the odd field both fall in the same clock. In the even field vertical sync falls at mid-line while horizontal sync is high. The 625-line system uses a vertical sync pulse two and a half lines long, so its two edges fall on opposite half-line points.

Top module: `interlace_sync_gen`

## Requirements
- R1: While reset is held and in the first cycle of reset, the outputs show line 1, pixel slot 0, hsyncN=0, vsyncN=0 and fieldEven=0. vbiBlank equals the inverse of vbiOff.
- R2: pixSlot steps by one each clock from 0 to PIX_A-1 (fmtSel=0) or PIX_B-1 (fmtSel=1) and then returns to 0. lineNum advances by one each time pixSlot returns to 0. lineNum wraps from 525 (fmtSel=0) or 625 (fmtSel=1) back to 1.
- R3: hsyncN is 0 exactly when pixSlot < HS_W. Its falling edge is therefore at slot 0, which is a Cb slot: slots repeat in the order Cb, Y, Cr, Y, and Cb slots are the multiples of 4.
- R4: With fmtSel=0, vsyncN is 0 on lines 1 to 3. It is also 0 from the half-line point (pixSlot >= PIX_A/2) of line 263 until the half-line point of line 266.
- R5: With fmtSel=1, vsyncN is 0 from line 1 slot 0 until the half-line point (pixSlot >= PIX_B/2) of line 3. It is also 0 from the half-line point of line 313 until line 316 slot 0.
- R6: When vsyncN falls at the start of the odd field, hsyncN falls in the same clock. When vsyncN falls at the start of the even field, hsyncN is high.
- R7: fieldEven is 0 on lines 1 to 262 (fmtSel=0) or 1 to 312 (fmtSel=1), and 1 on the remaining lines of the frame.
- R8: With fmtSel=0 and vbiOff=0, vbiBlank is 1 on lines 1-21, 262-284 and 525, and 0 elsewhere.
- R9: With fmtSel=1 and vbiOff=0, vbiBlank is 1 on lines 1-22, 311-335 and 624-625, and 0 elsewhere.
- R10: With vbiOff=1, vbiBlank stays 0 on every line in both systems.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz pixel-bus clock |
| rst | input | 1 | Synchronous active-high reset |
| fmtSel | input | 1 | 0 selects 525-line timing, 1 selects 625-line timing |
| vbiOff | input | 1 | 1 disables vertical-interval blanking |
| hsyncN | output | 1 | Horizontal sync, active low |
| vsyncN | output | 1 | Vertical sync, active low |
| fieldEven | output | 1 | 0 in the odd field, 1 in the even field |
| lineNum | output | 10 | Current line, counted from 1 |
| pixSlot | output | 11 | Current pixel-bus slot within the line, counted from 0 |
| vbiBlank | output | 1 | 1 on blanked vertical-interval lines |

## Verification
The bench runs whole frames of both systems, with and without blanking, on a configuration with shortened lines. It compares every output on every clock against a position model.

Several errors are aimed at directly:
- An error of one line at a wrap point, or of one half-line at a sync edge, would shift a vertical sync window. It would also break the rule that vertical sync falls exactly twice per frame, once together with horizontal sync and once without it.
- A blanking range that is off by one at either end shows up on that single line.
- An ignored blanking-disable input leaves the flag high inside the vertical interval.
- A line length taken from the wrong system pushes every later line out of step.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;
  // Per-clock strobes from the pixel control to the line datapath,
  // all describing the slot the counters move to at the next edge.
  typedef struct packed {
    logic lineStep;  // pixel counter wraps at this edge
    logic hsActive;  // next slot lies inside the horizontal sync pulse
    logic lateHalf;  // next slot lies in the second half of the line
  } pixStrobe_t;
endpackage

// File: rtl/sync_pix_ctrl.sv
module sync_pix_ctrl
  import sync_gen_pkg::*;
#(
  parameter int PIX_A = 1716,
  parameter int PIX_B = 1728,
  parameter int HS_W  = 64,
  parameter int PW    = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fmtSel,
  output logic [PW-1:0] pixSlot,
  output pixStrobe_t    strobe
);
  localparam logic [PW-1:0] LAST_A = PW'(PIX_A - 1);
  localparam logic [PW-1:0] LAST_B = PW'(PIX_B - 1);
  localparam logic [PW-1:0] HALF_A = PW'(PIX_A / 2);
  localparam logic [PW-1:0] HALF_B = PW'(PIX_B / 2);
  localparam logic [PW-1:0] HS_END = PW'(HS_W);

  logic [PW-1:0] pixCnt, pixNext, lastPix, halfPix;
  logic          atEnd;

  always_comb begin
    lastPix = fmtSel ? LAST_B : LAST_A;
    halfPix = fmtSel ? HALF_B : HALF_A;
    // >= so that a counter left past the end by a system change wraps at once
    atEnd   = (pixCnt >= lastPix);
    pixNext = atEnd ? '0 : pixCnt + PW'(1);
    strobe.lineStep = atEnd;
    strobe.hsActive = (pixNext < HS_END);
    strobe.lateHalf = (pixNext >= halfPix);
  end

  always_ff @(posedge clk) begin
    if (rst) pixCnt <= '0;
    else     pixCnt <= pixNext;
  end

  assign pixSlot = pixCnt;
endmodule

// File: rtl/sync_line_dp.sv
module sync_line_dp
  import sync_gen_pkg::*;
#(
  parameter int LINES_A = 525,
  parameter int LINES_B = 625,
  parameter int LW      = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fmtSel,
  input  logic          vbiOff,
  input  pixStrobe_t    strobe,
  output logic [LW-1:0] lineNum,
  output logic          hsyncN,
  output logic          vsyncN,
  output logic          fieldEven,
  output logic          vbiBlank
);
  localparam int EVEN_A = LINES_A / 2 + 1;  // 263
  localparam int EVEN_B = LINES_B / 2 + 1;  // 313

  logic [LW-1:0] lineCnt, lineNext;
  logic          vsLow, evenNext, blankNext;
  int            ln;

  function automatic logic inSpan(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  always_comb begin
    if (!strobe.lineStep)
      lineNext = lineCnt;
    else if (int'(lineCnt) >= (fmtSel ? LINES_B : LINES_A))
      lineNext = LW'(1);
    else
      lineNext = lineCnt + LW'(1);
    ln = int'(lineNext);

    if (!fmtSel) begin
      // three-line pulses; even one starts and ends at mid-line
      vsLow = inSpan(ln, 1, 3)
            | ((ln == EVEN_A) & strobe.lateHalf)
            | inSpan(ln, EVEN_A + 1, EVEN_A + 2)
            | ((ln == EVEN_A + 3) & !strobe.lateHalf);
      evenNext  = (ln >= EVEN_A);
      blankNext = inSpan(ln, 1, 21) | inSpan(ln, 262, 284) | (ln == LINES_A);
    end else begin
      // two-and-a-half-line pulses
      vsLow = inSpan(ln, 1, 2)
            | ((ln == 3) & !strobe.lateHalf)
            | ((ln == EVEN_B) & strobe.lateHalf)
            | inSpan(ln, EVEN_B + 1, EVEN_B + 2);
      evenNext  = (ln >= EVEN_B);
      blankNext = inSpan(ln, 1, 22) | inSpan(ln, 311, 335)
                | inSpan(ln, LINES_B - 1, LINES_B);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lineCnt   <= LW'(1);
      hsyncN    <= 1'b0;
      vsyncN    <= 1'b0;
      fieldEven <= 1'b0;
      vbiBlank  <= !vbiOff;
    end else begin
      lineCnt   <= lineNext;
      hsyncN    <= !strobe.hsActive;
      vsyncN    <= !vsLow;
      fieldEven <= evenNext;
      vbiBlank  <= blankNext & !vbiOff;
    end
  end

  assign lineNum = lineCnt;
endmodule

// File: rtl/interlace_sync_gen.sv
module interlace_sync_gen
  import sync_gen_pkg::*;
#(
  parameter int PIX_A   = 1716,
  parameter int PIX_B   = 1728,
  parameter int HS_W    = 64,
  parameter int LINES_A = 525,
  parameter int LINES_B = 625,
  localparam int PW = $clog2((PIX_A > PIX_B) ? PIX_A : PIX_B),
  localparam int LW = $clog2(((LINES_A > LINES_B) ? LINES_A : LINES_B) + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fmtSel,
  input  logic          vbiOff,
  output logic          hsyncN,
  output logic          vsyncN,
  output logic          fieldEven,
  output logic [LW-1:0] lineNum,
  output logic [PW-1:0] pixSlot,
  output logic          vbiBlank
);
  pixStrobe_t strobe;

  sync_pix_ctrl #(.PIX_A(PIX_A), .PIX_B(PIX_B), .HS_W(HS_W), .PW(PW)) u_ctrl (
    .clk(clk), .rst(rst), .fmtSel(fmtSel), .pixSlot(pixSlot), .strobe(strobe)
  );

  sync_line_dp #(.LINES_A(LINES_A), .LINES_B(LINES_B), .LW(LW)) u_dp (
    .clk(clk), .rst(rst), .fmtSel(fmtSel), .vbiOff(vbiOff), .strobe(strobe),
    .lineNum(lineNum), .hsyncN(hsyncN), .vsyncN(vsyncN),
    .fieldEven(fieldEven), .vbiBlank(vbiBlank)
  );
endmodule

// File: rtl/sync_gen_chk.sv
module sync_gen_chk #(
  parameter int HS_W = 64,
  parameter int PW   = 11,
  parameter int LW   = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          vbiOff,
  input logic          hsyncN,
  input logic          vsyncN,
  input logic          fieldEven,
  input logic [LW-1:0] lineNum,
  input logic [PW-1:0] pixSlot,
  input logic          vbiBlank
);
  p_pix_step_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pixSlot == '0) || (pixSlot == $past(pixSlot) + PW'(1)));

  p_line_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (pixSlot != '0) |-> $stable(lineNum));

  p_hs_fall_cb_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(hsyncN) |-> (pixSlot == '0) && (pixSlot[1:0] == 2'b00));

  p_hs_width_r3: assert property (@(posedge clk) disable iff (rst)
    !hsyncN |-> (int'(pixSlot) < HS_W));

  p_odd_start_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(vsyncN) && $fell(hsyncN)) |-> (lineNum == LW'(1)) && !fieldEven);

  p_even_start_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(vsyncN) && hsyncN) |-> fieldEven);

  p_blank_off_r10: assert property (@(posedge clk) disable iff (rst)
    $past(vbiOff) |-> !vbiBlank);
endmodule

bind interlace_sync_gen sync_gen_chk #(.HS_W(HS_W), .PW(PW), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .vbiOff(vbiOff), .hsyncN(hsyncN), .vsyncN(vsyncN),
  .fieldEven(fieldEven), .lineNum(lineNum), .pixSlot(pixSlot),
  .vbiBlank(vbiBlank)
);

// File: tb/tb_interlace_sync_gen.sv
module tb_interlace_sync_gen;
  localparam int PIX_A = 40;
  localparam int PIX_B = 48;
  localparam int HS_W  = 8;
  localparam int PW    = $clog2(PIX_B);
  localparam int LW    = 10;

  logic clk = 1'b0, rst = 1'b1, fmtSel = 1'b0, vbiOff = 1'b0;
  logic hsyncN, vsyncN, fieldEven, vbiBlank;
  logic [LW-1:0] lineNum;
  logic [PW-1:0] pixSlot;
  int checks = 0, errors = 0;

  interlace_sync_gen #(.PIX_A(PIX_A), .PIX_B(PIX_B), .HS_W(HS_W)) dut (
    .clk(clk), .rst(rst), .fmtSel(fmtSel), .vbiOff(vbiOff),
    .hsyncN(hsyncN), .vsyncN(vsyncN), .fieldEven(fieldEven),
    .lineNum(lineNum), .pixSlot(pixSlot), .vbiBlank(vbiBlank)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic bit expVsLow(input int l, input int p, input bit fmt);
    bit late;
    late = p >= ((fmt ? PIX_B : PIX_A) / 2);
    if (!fmt) return (l >= 1 && l <= 3) || (l == 263 && late) ||
                     (l == 264) || (l == 265) || (l == 266 && !late);
    return (l == 1) || (l == 2) || (l == 3 && !late) ||
           (l == 313 && late) || (l == 314) || (l == 315);
  endfunction

  function automatic bit expBlank(input int l, input bit fmt, input bit off);
    if (off) return 1'b0;
    if (!fmt) return (l <= 21) || (l >= 262 && l <= 284) || (l == 525);
    return (l <= 22) || (l >= 311 && l <= 335) || (l >= 624);
  endfunction

  task automatic runSweep(input bit fmt, input bit off);
    int l, p, lines, pix, nPos, nHs, nVs, nFld, nBlk, nR6, vsFalls;
    string fPos, fHs, fVs, fFld, fBlk, fR6, vsReq, blkReq;
    bit prevV, prevH, expEven;
    lines = fmt ? 625 : 525;
    pix   = fmt ? PIX_B : PIX_A;
    vsReq = fmt ? "R5" : "R4";
    blkReq = off ? "R10" : (fmt ? "R9" : "R8");
    nPos = 0; nHs = 0; nVs = 0; nFld = 0; nBlk = 0; nR6 = 0; vsFalls = 0;
    @(negedge clk);
    rst = 1'b1; fmtSel = fmt; vbiOff = off;
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check(lineNum == 1 && pixSlot == 0,
          $sformatf("R1 reset position act %0d/%0d exp 1/0", lineNum, pixSlot));
    check(!hsyncN && !vsyncN && !fieldEven && (vbiBlank == !off),
          $sformatf("R1 reset flags act hs%b vs%b f%b b%b exp hs0 vs0 f0 b%b",
                    hsyncN, vsyncN, fieldEven, vbiBlank, !off));
    rst = 1'b0;
    l = 1; p = 0; prevV = 1'b0; prevH = 1'b0;
    for (int c = 0; c < lines * pix + pix; c++) begin
      if (p == pix - 1) begin
        p = 0;
        l = (l == lines) ? 1 : l + 1;
      end else p++;
      @(negedge clk);
      if (int'(lineNum) != l || int'(pixSlot) != p) begin
        if (nPos == 0) fPos = $sformatf("act %0d/%0d exp %0d/%0d", lineNum, pixSlot, l, p);
        nPos++;
      end
      if (hsyncN != !(p < HS_W)) begin
        if (nHs == 0) fHs = $sformatf("act %b exp %b at %0d/%0d", hsyncN, !(p < HS_W), l, p);
        nHs++;
      end
      if (vsyncN != !expVsLow(l, p, fmt)) begin
        if (nVs == 0) fVs = $sformatf("act %b exp %b at %0d/%0d", vsyncN, !expVsLow(l, p, fmt), l, p);
        nVs++;
      end
      expEven = l >= (fmt ? 313 : 263);
      if (fieldEven != expEven) begin
        if (nFld == 0) fFld = $sformatf("act %b exp %b at line %0d", fieldEven, expEven, l);
        nFld++;
      end
      if (vbiBlank != expBlank(l, fmt, off)) begin
        if (nBlk == 0) fBlk = $sformatf("act %b exp %b at line %0d", vbiBlank, expBlank(l, fmt, off), l);
        nBlk++;
      end
      if (prevV && !vsyncN) begin
        vsFalls++;
        // odd start: hsync falls together; even start: hsync high
        if (fieldEven ? !hsyncN : !(prevH && !hsyncN)) begin
          if (nR6 == 0) fR6 = $sformatf("act hs %b->%b f%b exp %s", prevH, hsyncN, fieldEven,
                                        fieldEven ? "hs high" : "hs falling");
          nR6++;
        end
      end
      prevV = vsyncN; prevH = hsyncN;
    end
    check(nPos == 0, $sformatf("R2 fmt%0d counters %0d bad, first %s", fmt, nPos, fPos));
    check(nHs == 0, $sformatf("R3 fmt%0d hsync %0d bad, first %s", fmt, nHs, fHs));
    check(nVs == 0, $sformatf("%s vsync %0d bad, first %s", vsReq, nVs, fVs));
    check(nR6 == 0, $sformatf("R6 fmt%0d field-start phase, first %s", fmt, fR6));
    check(vsFalls == 2, $sformatf("R6 fmt%0d vsync falls act %0d exp 2", fmt, vsFalls));
    check(nFld == 0, $sformatf("R7 fmt%0d field %0d bad, first %s", fmt, nFld, fFld));
    check(nBlk == 0, $sformatf("%s blank %0d bad, first %s", blkReq, nBlk, fBlk));
  endtask

  initial begin
    runSweep(1'b0, 1'b0);
    runSweep(1'b1, 1'b0);
    runSweep(1'b0, 1'b1);
    runSweep(1'b1, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(180000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog expired act running exp done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule